// File: doc/BRIEF.md
# Mersenne-61 Multiplicative Random Number Generator

This block produces a stream of pseudo-random 61-bit integers from the multiplicative recurrence Z(n) = a·Z(n-1) mod (2^61 − 1). A 61-bit coefficient and a 61-bit nonzero starting value are presented on split ports, each as a 31-bit low part and a 30-bit high part. After a synchronous reset, the block captures both values on its first operation. From then on it feeds each reduced result back as the next operand.

The 61×61 product is formed from four 32×32 partial products in a two-stage loop. The first stage registers the operands and the second registers the partial products. Recombination, Mersenne folding and the zero-avoidance fix are combinational and sit after the product registers, so a new result appears every other clock cycle. The output side has a plain valid strobe and no ready input. A consumer that needs to stall drives `en` low, which freezes the whole loop, and no result is lost or repeated.

Top module: `mersenne61_rng`

## Requirements
- R1: While `rst` is high at a rising edge, `rnd_valid` is low after that edge. The first result after reset equals coef·seed mod (2^61−1), where seed = {seed_hi, seed_lo} and coef = {coef_hi, coef_lo}, with the high part in bits 60:31.
- R2: Each later result equals coef times the previous result, mod (2^61−1).
- R3: With `en` held high after reset, `rnd_valid` is low after the first rising edge and high after the second, then alternates low and high on every edge. It is never high on two edges in a row.
- R4: `rnd` keeps its value on the edge that follows a valid pulse, so each result is stable for two cycles.
- R5: While `en` is low, `rnd_valid` is low and `rnd` does not change. When `en` returns high, the sequence resumes with the next result and none is skipped.
- R6: The block never outputs zero. A starting value of all ones (congruent to zero) gives a first result of 1.
- R7: Every valid result is strictly less than 2^61−1.
- R8: The coefficient and seed ports are sampled only at the first operation after reset. Changing them later has no effect on the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | High to run; low freezes all state |
| seed_lo | input | 31 | Starting value, bits 30:0 |
| seed_hi | input | 30 | Starting value, bits 60:31 |
| coef_lo | input | 31 | Multiplier coefficient, bits 30:0 |
| coef_hi | input | 30 | Multiplier coefficient, bits 60:31 |
| rnd | output | 61 | Current result |
| rnd_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
The recurrence runs with four coefficient/seed pairs, and six results from each are compared against a wide-integer model.

- A small coefficient with seed 1 checks the low partial product and the feedback path, with few carries into the fold.
- A pair of dense random-looking operands exercises all four cross products at once.
- A coefficient and seed both equal to 2^61−2 force the folded sum above bit 61, which exposes errors in the carry-and-increment path.
- A pair with the seed at the 31-bit split boundary catches misplaced shifts between the low and high halves.

Directed runs then check freezing, ignoring of changed inputs after the first load, and the all-ones seed that must turn into 1.

// File: rtl/mrng_pkg.sv
package mrng_pkg;
  localparam int unsigned STATE_W = 61;
  localparam int unsigned LO_W    = 31;
  localparam int unsigned HI_W    = STATE_W - LO_W;
  localparam int unsigned MUL_W   = 32;
  localparam int unsigned PROD_W  = 2 * MUL_W;
  localparam int unsigned FULL_W  = 2 * STATE_W;
  localparam int unsigned NPART   = 2;

  typedef logic [STATE_W-1:0] state_t;
  typedef logic [MUL_W-1:0]   half_t;
  typedef logic [PROD_W-1:0]  prod_t;
endpackage

// File: rtl/mrng_operand_reg.sv
module mrng_operand_reg
  import mrng_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   load,
  input  logic   use_seed,
  input  state_t seed,
  input  state_t coef,
  input  state_t fb,
  output half_t  z_part [NPART],
  output half_t  a_part [NPART]
);
  state_t z_q, a_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      z_q <= '0;
      a_q <= '0;
    end else if (load) begin
      if (use_seed) begin
        z_q <= seed;
        a_q <= coef;
      end else begin
        z_q <= fb;
      end
    end
  end

  // low part padded with one zero, high part with two zeros
  assign z_part[0] = {{(MUL_W-LO_W){1'b0}}, z_q[LO_W-1:0]};
  assign z_part[1] = {{(MUL_W-HI_W){1'b0}}, z_q[STATE_W-1:LO_W]};
  assign a_part[0] = {{(MUL_W-LO_W){1'b0}}, a_q[LO_W-1:0]};
  assign a_part[1] = {{(MUL_W-HI_W){1'b0}}, a_q[STATE_W-1:LO_W]};

  // R8: coefficient register never moves after the first load
  p_coef_kept_r8: assert property (@(posedge clk) disable iff (rst)
    (load && !use_seed) |=> $stable(a_q));
endmodule

// File: rtl/mrng_mul.sv
module mrng_mul #(
  parameter int unsigned IN_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic [IN_W-1:0]   x,
  input  logic [IN_W-1:0]   y,
  output logic [2*IN_W-1:0] p
);
  always_ff @(posedge clk) begin
    if (rst) p <= '0;
    else if (cap) p <= (2*IN_W)'(x) * (2*IN_W)'(y);
  end
endmodule

// File: rtl/mrng_fold.sv
module mrng_fold
  import mrng_pkg::*;
(
  input  prod_t  pp [NPART*NPART],
  output state_t res
);
  localparam state_t MODV = '1;

  logic [FULL_W-1:0]  full;
  logic [STATE_W:0]   s;
  logic [STATE_W:0]   t;

  always_comb begin
    // index = z_idx*2 + a_idx ; cross terms shifted by LO_W, top term by 2*LO_W
    full = FULL_W'(pp[0])
         + ((FULL_W'(pp[1]) + FULL_W'(pp[2])) << LO_W)
         + (FULL_W'(pp[3]) << (2*LO_W));
    s = {1'b0, full[STATE_W-1:0]} + {1'b0, full[FULL_W-1:STATE_W]};
    if (s[STATE_W]) t = {1'b0, s[STATE_W-1:0]} + 1'b1;
    else            t = s;
    if (t[STATE_W] || (t[STATE_W-1:0] == MODV)) res = state_t'(1);
    else                                         res = t[STATE_W-1:0];
  end
endmodule

// File: rtl/mersenne61_rng.sv
module mersenne61_rng
  import mrng_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [LO_W-1:0]   seed_lo,
  input  logic [HI_W-1:0]   seed_hi,
  input  logic [LO_W-1:0]   coef_lo,
  input  logic [HI_W-1:0]   coef_hi,
  output logic [STATE_W-1:0] rnd,
  output logic              rnd_valid
);
  logic ph_q, started_q, vld_q;
  logic load, cap;
  half_t  z_part [NPART];
  half_t  a_part [NPART];
  prod_t  pp [NPART*NPART];
  state_t res;

  assign load = en & ~ph_q;
  assign cap  = en &  ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= 1'b0;
      started_q <= 1'b0;
      vld_q     <= 1'b0;
    end else if (en) begin
      ph_q  <= ~ph_q;
      vld_q <= ph_q;
      if (!ph_q) started_q <= 1'b1;
    end
  end

  mrng_operand_reg u_ops (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .use_seed (~started_q),
    .seed     ({seed_hi, seed_lo}),
    .coef     ({coef_hi, coef_lo}),
    .fb       (res),
    .z_part   (z_part),
    .a_part   (a_part)
  );

  for (genvar gz = 0; gz < NPART; gz++) begin : g_z
    for (genvar ga = 0; ga < NPART; ga++) begin : g_a
      mrng_mul #(.IN_W(MUL_W)) u_mul (
        .clk (clk),
        .rst (rst),
        .cap (cap),
        .x   (z_part[gz]),
        .y   (a_part[ga]),
        .p   (pp[gz*NPART+ga])
      );
    end
  end

  mrng_fold u_fold (
    .pp  (pp),
    .res (res)
  );

  assign rnd       = res;
  assign rnd_valid = vld_q & en;

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !vld_q);
  p_pulse_gap_r3: assert property (@(posedge clk) disable iff (rst)
    rnd_valid |=> !rnd_valid);
  p_hold_after_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    rnd_valid |=> $stable(rnd));
  p_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(rnd) && $stable(vld_q)));
  p_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> (rnd != '0));
  p_below_mod_r7: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> (rnd != '1));
endmodule

// File: tb/tb_mersenne61_rng.sv
module tb_mersenne61_rng;
  localparam int CLK_PERIOD = 10;
  localparam logic [60:0] MODV = '1;
  localparam int NVEC = 4;
  localparam int NOUT = 6;
  // {coef, seed}
  localparam logic [121:0] VEC [NVEC] = '{
    {61'd48271,                 61'd1},
    {61'h0123_4567_89AB_CDEF,   61'h1ABC_DEF0_1234_5678},
    {61'h1FFF_FFFF_FFFF_FFFE,   61'h1FFF_FFFF_FFFF_FFFE},
    {61'h1000_0000_0000_0001,   61'h0000_0000_7FFF_FFFF}
  };

  logic        clk, rst, en;
  logic [30:0] seed_lo, coef_lo;
  logic [29:0] seed_hi, coef_hi;
  logic [60:0] rnd;
  logic        rnd_valid;
  int total, bad;
  logic done;

  mersenne61_rng dut (
    .clk(clk), .rst(rst), .en(en),
    .seed_lo(seed_lo), .seed_hi(seed_hi),
    .coef_lo(coef_lo), .coef_hi(coef_hi),
    .rnd(rnd), .rnd_valid(rnd_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [60:0] ref_step(logic [60:0] a, logic [60:0] z);
    logic [121:0] p;
    p = 122'(a) * 122'(z);
    p = p % 122'(MODV);
    if (p == '0) return 61'd1;
    return p[60:0];
  endfunction

  task automatic check(string req, logic [60:0] act, logic [60:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [60:0] c, logic [60:0] s);
    coef_lo = c[30:0]; coef_hi = c[60:31];
    seed_lo = s[30:0]; seed_hi = s[60:31];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; en = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 valid low after reset", 61'(rnd_valid), 61'd0);
  endtask

  // one result: an idle edge then a valid edge
  task automatic step_out(string req, logic [60:0] exp, logic [60:0] prev);
    @(posedge clk); #1;
    check("R3 valid low on load edge", 61'(rnd_valid), 61'd0);
    check("R4 result held", rnd, prev);
    @(posedge clk); #1;
    check("R3 valid high on product edge", 61'(rnd_valid), 61'd1);
    check(req, rnd, exp);
    check("R7 below modulus", 61'(rnd != MODV), 61'd1);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [60:0] c, s, e, p;
    total = 0; bad = 0; done = 1'b0;
    rst = 1'b1; en = 1'b1;
    drive('0, 61'd1);

    // table walk: R1 first result, R2 recurrence
    for (int v = 0; v < NVEC; v++) begin
      c = VEC[v][121:61]; s = VEC[v][60:0];
      drive(c, s);
      do_reset();
      e = s; p = '0;
      for (int k = 0; k < NOUT; k++) begin
        e = ref_step(c, e);
        step_out(k == 0 ? "R1 first result" : "R2 recurrence", e, p);
        p = e;
      end
    end

    // R8: input changes after the first load are ignored
    c = VEC[1][121:61]; s = VEC[1][60:0];
    drive(c, s);
    do_reset();
    e = ref_step(c, s);
    step_out("R8 first", e, '0);
    drive(61'h0555_5555_5555_5555, 61'h0AAA_AAAA_AAAA_AAAA);
    p = e;
    for (int k = 0; k < 3; k++) begin
      e = ref_step(c, e);
      step_out("R8 inputs ignored", e, p);
      p = e;
    end

    // R5: freeze and resume
    drive(c, s);
    do_reset();
    e = ref_step(c, s);
    step_out("R5 pre-freeze", e, '0);
    p = e;
    en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      check("R5 valid low while frozen", 61'(rnd_valid), 61'd0);
      check("R5 result held while frozen", rnd, p);
    end
    @(negedge clk);
    en = 1'b1;
    for (int k = 0; k < 2; k++) begin
      e = ref_step(c, e);
      step_out("R5 resumed without skip", e, p);
      p = e;
    end

    // R6: seed congruent to zero becomes 1
    drive(c, MODV);
    do_reset();
    step_out("R6 zero replaced by one", 61'd1, '0);
    e = ref_step(c, 61'd1);
    step_out("R6 continues from one", e, 61'd1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule